// File: doc/BRIEF.md
# Multi-Port Memory Wrapper with Bus Conflict Resolution and Word Alignment

This block fronts a small on-chip array of 16-bit words for a processor that keeps its program and data traffic on separate buses. It offers three ports: a program port that can read or write, a data-read port, and a data-write port. The program port has one address bus that both of its directions use. Both program writes and data writes take their write data from a single shared write-data input.

The wrapper grants every request whose buses are free in the same cycle. When two requests need the same physical bus, it stalls one of them by holding that port's ready low, and the requester retries on a later cycle. Any 32-bit access is forced onto an even word boundary inside the wrapper. The requester's address is used only for this internal index, and the wrapper never modifies it or returns it.

Reads are combinational from the array. Writes commit on the rising clock edge, so a read in the same cycle still sees the old contents.

Top module: `mbw_top`

## Requirements
- R1: A program write request is always accepted: `p_wr_ready` equals `p_wr_req` in every cycle.
- R2: When a program read and a program write are both requested in one cycle, the write is accepted and `p_rd_ready` stays low. A program read with no program write pending is accepted in the same cycle.
- R3: When a program write and a data write are both requested in one cycle, only the program write commits. `d_wr_ready` stays low, and the word at the data-write address keeps its old value.
- R4: A data read is always accepted in the cycle it is requested. A program read, a data read and a data write can all be accepted in one cycle when no program write is requested.
- R5: A 32-bit read (wide input = 1) at word address A returns `{word[A|1], word[A&~1]}`. An odd A is therefore rounded down to the even word, and the higher-addressed word sits in bits 31:16.
- R6: A 32-bit write at word address A stores `wr_data[15:0]` to word A&~1 and `wr_data[31:16]` to word (A&~1)+1.
- R7: A 16-bit access (wide input = 0) uses the exact word address. A 16-bit read returns the word in bits 15:0 with bits 31:16 zero. A 16-bit write stores only `wr_data[15:0]` and leaves the neighbouring word unchanged.
- R8: A read of a word that is written in the same cycle returns the old contents. The new value is visible from the next cycle on.
- R9: Reset clears every word to zero. With no request pending, all four ready outputs are 0. The array is indexed by the low `IDX_W` bits (default 8) of each address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears the array |
| p_rd_req | input | 1 | Program read request |
| p_wr_req | input | 1 | Program write request |
| p_wide | input | 1 | Program access size: 1 = 32-bit, 0 = 16-bit |
| p_addr | input | PA_W (22) | Program word address, shared by both program directions |
| p_rdata | output | 32 | Program read data |
| p_rd_ready | output | 1 | Program read accepted this cycle |
| p_wr_ready | output | 1 | Program write accepted this cycle |
| d_rd_req | input | 1 | Data read request |
| d_rd_wide | input | 1 | Data read size: 1 = 32-bit, 0 = 16-bit |
| d_rd_addr | input | DA_W (32) | Data read word address |
| d_rdata | output | 32 | Data read data |
| d_rd_ready | output | 1 | Data read accepted this cycle |
| d_wr_req | input | 1 | Data write request |
| d_wr_wide | input | 1 | Data write size: 1 = 32-bit, 0 = 16-bit |
| d_wr_addr | input | DA_W (32) | Data write word address |
| d_wr_ready | output | 1 | Data write accepted this cycle |
| wr_data | input | 32 | Shared write data, owned by the granted writer |

## Verification
A faulty grant decision shows up on the ready outputs in the same cycle as the request. It also shows up one cycle later as a word that was or was not overwritten. A wrong alignment or half ordering is visible immediately on `p_rdata` or `d_rdata` when the port reads an odd address with the wide size selected. A write that lands in the wrong word, or that clobbers a neighbour, is exposed by the first later read of either word, which is compared against a reference model updated only by the grants the bench expects. A read that leaks the value being written in the same cycle is caught at once by a same-address read paired with a write.

// File: rtl/mbw_pkg.sv
package mbw_pkg;

  typedef struct packed {
    logic prd;
    logic pwr;
    logic drd;
    logic dwr;
  } grant_t;

  // Word address of the low half of an access: even for 32-bit, exact for 16-bit.
  function automatic logic [31:0] mbw_lo_word(input logic [31:0] addr, input logic wide);
    return wide ? {addr[31:1], 1'b0} : addr;
  endfunction

  // Word address of the high half: the following odd word for 32-bit, else same word.
  function automatic logic [31:0] mbw_hi_word(input logic [31:0] addr, input logic wide);
    return wide ? {addr[31:1], 1'b1} : addr;
  endfunction

endpackage

// File: rtl/mbw_align.sv
module mbw_align #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic [IN_W-1:0]  addr,
  input  logic             wide,
  output logic [IDX_W-1:0] lo_idx,
  output logic [IDX_W-1:0] hi_idx
);
  import mbw_pkg::*;

  logic [31:0] ext_addr;
  logic [31:0] lo_full;
  logic [31:0] hi_full;

  always_comb begin
    ext_addr = 32'(addr);
    lo_full  = mbw_lo_word(ext_addr, wide);
    hi_full  = mbw_hi_word(ext_addr, wide);
  end

  assign lo_idx = lo_full[IDX_W-1:0];
  assign hi_idx = hi_full[IDX_W-1:0];

  // R5: a wide access never starts on an odd word.
  always_comb begin
    assert_even_start_R5: assert (!wide || lo_idx[0] == 1'b0);
  end

endmodule

// File: rtl/mbw_arb.sv
module mbw_arb (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_rd_req,
  input  logic             p_wr_req,
  input  logic             d_rd_req,
  input  logic             d_wr_req,
  output mbw_pkg::grant_t  grant,
  output logic             pab_clash,
  output logic             wdb_clash
);
  import mbw_pkg::*;

  // Events on the two shared buses.
  assign pab_clash = p_rd_req && p_wr_req;
  assign wdb_clash = p_wr_req && d_wr_req;

  always_comb begin
    grant.pwr = p_wr_req;
    grant.prd = p_rd_req && !pab_clash;
    grant.drd = d_rd_req;
    grant.dwr = d_wr_req && !wdb_clash;
  end

  assert_pab_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant.prd && grant.pwr));

  assert_wdb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({grant.pwr, grant.dwr}) <= 1);

  assert_pwr_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pab_clash || wdb_clash) |-> grant.pwr);

  assert_no_false_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_wr_req && p_rd_req && d_rd_req && d_wr_req) |-> (grant.prd && grant.drd && grant.dwr));

endmodule

// File: rtl/mbw_store.sv
module mbw_store #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned NRD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_wide,
  input  logic [IDX_W-1:0] wr_lo,
  input  logic [IDX_W-1:0] wr_hi,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_lo   [NRD],
  input  logic [IDX_W-1:0] rd_hi   [NRD],
  input  logic             rd_wide [NRD],
  output logic [31:0]      rd_data [NRD]
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [15:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_lo] <= wr_data[15:0];
      if (wr_wide) mem_q[wr_hi] <= wr_data[31:16];
    end
  end

  // Combinational reads: a same-cycle write is not yet visible (R8).
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = rd_wide[g] ? {mem_q[rd_hi[g]], mem_q[rd_lo[g]]}
                                   : {16'h0000, mem_q[rd_lo[g]]};
  end

  assert_low_half_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_lo)] == $past(wr_data[15:0]));

  assert_high_half_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wide) |=> mem_q[$past(wr_hi)] == $past(wr_data[31:16]));

  assert_narrow_neighbour_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide) |=> mem_q[$past(wr_lo) ^ IDX_W'(1)] == $past(mem_q[wr_lo ^ IDX_W'(1)]));

endmodule

// File: rtl/mbw_top.sv
module mbw_top #(
  parameter int unsigned PA_W  = 22,
  parameter int unsigned DA_W  = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            p_rd_req,
  input  logic            p_wr_req,
  input  logic            p_wide,
  input  logic [PA_W-1:0] p_addr,
  output logic [31:0]     p_rdata,
  output logic            p_rd_ready,
  output logic            p_wr_ready,
  input  logic            d_rd_req,
  input  logic            d_rd_wide,
  input  logic [DA_W-1:0] d_rd_addr,
  output logic [31:0]     d_rdata,
  output logic            d_rd_ready,
  input  logic            d_wr_req,
  input  logic            d_wr_wide,
  input  logic [DA_W-1:0] d_wr_addr,
  output logic            d_wr_ready,
  input  logic [31:0]     wr_data
);
  import mbw_pkg::*;

  localparam int unsigned NRD = 2;

  grant_t           grant;
  logic             pab_clash;
  logic             wdb_clash;
  logic [IDX_W-1:0] p_lo, p_hi, dr_lo, dr_hi, dw_lo, dw_hi;
  logic             wr_en, wr_wide;
  logic [IDX_W-1:0] wr_lo, wr_hi;
  logic [IDX_W-1:0] rd_lo   [NRD];
  logic [IDX_W-1:0] rd_hi   [NRD];
  logic             rd_wide [NRD];
  logic [31:0]      rd_data [NRD];

  mbw_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .p_rd_req(p_rd_req), .p_wr_req(p_wr_req),
    .d_rd_req(d_rd_req), .d_wr_req(d_wr_req),
    .grant(grant), .pab_clash(pab_clash), .wdb_clash(wdb_clash)
  );

  mbw_align #(.IN_W(PA_W), .IDX_W(IDX_W)) u_al_p (
    .addr(p_addr), .wide(p_wide), .lo_idx(p_lo), .hi_idx(p_hi));
  mbw_align #(.IN_W(DA_W), .IDX_W(IDX_W)) u_al_dr (
    .addr(d_rd_addr), .wide(d_rd_wide), .lo_idx(dr_lo), .hi_idx(dr_hi));
  mbw_align #(.IN_W(DA_W), .IDX_W(IDX_W)) u_al_dw (
    .addr(d_wr_addr), .wide(d_wr_wide), .lo_idx(dw_lo), .hi_idx(dw_hi));

  // Single write path: the shared write data bus belongs to the granted writer.
  assign wr_en   = grant.pwr || grant.dwr;
  assign wr_wide = grant.pwr ? p_wide : d_wr_wide;
  assign wr_lo   = grant.pwr ? p_lo   : dw_lo;
  assign wr_hi   = grant.pwr ? p_hi   : dw_hi;

  assign rd_lo[0]   = p_lo;
  assign rd_hi[0]   = p_hi;
  assign rd_wide[0] = p_wide;
  assign rd_lo[1]   = dr_lo;
  assign rd_hi[1]   = dr_hi;
  assign rd_wide[1] = d_rd_wide;

  mbw_store #(.IDX_W(IDX_W), .NRD(NRD)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_wide(rd_wide), .rd_data(rd_data)
  );

  assign p_rdata    = rd_data[0];
  assign d_rdata    = rd_data[1];
  assign p_rd_ready = grant.prd;
  assign p_wr_ready = grant.pwr;
  assign d_rd_ready = grant.drd;
  assign d_wr_ready = grant.dwr;

  assert_stalled_dwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wdb_clash |-> (wr_lo == p_lo && !d_wr_ready));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_rd_req || p_wr_req || d_rd_req || d_wr_req) |-> !wr_en);

endmodule

// File: tb/mbw_top_tb_top.sv
module mbw_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic        prd, pwr, drd, dwr;
    logic        pw, drw, dww;
    logic [21:0] pa;
    logic [31:0] ra;
    logic [31:0] wa;
    logic [31:0] wd;
  } vec_t;

  // Stimulus table; expected values come from the reference model below.
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 22'd5, 32'd0, 32'd0, 32'hAAAA_BBBB}, // R1 R6 odd wide pwrite
    '{1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b1, 22'd5, 32'd4, 32'd9, 32'h1111_2222}, // R4 R5 R7 three-way
    '{1'b0,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0, 22'd3, 32'd9, 32'd3, 32'h0000_CCCC}, // R3 clash
    '{1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0, 22'd0, 32'd3, 32'd3, 32'h5555_DDDD}, // R8 R7 same word
    '{1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 22'd8, 32'd0, 32'd0, 32'h7777_EEEE}, // R2 clash
    '{1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0, 22'd9, 32'd3, 32'd0, 32'h0},         // R5 R7 readback
    '{1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1, 22'd0, 32'd7, 32'd7, 32'h9999_8888}, // R6 R8 odd wide dwrite
    '{1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0, 22'd6, 32'd3, 32'd0, 32'h0}          // R5 readback
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p_rd_req = 0, p_wr_req = 0, p_wide = 0;
  logic [21:0] p_addr = '0;
  logic [31:0] p_rdata;
  logic        p_rd_ready, p_wr_ready;
  logic        d_rd_req = 0, d_rd_wide = 0;
  logic [31:0] d_rd_addr = '0;
  logic [31:0] d_rdata;
  logic        d_rd_ready;
  logic        d_wr_req = 0, d_wr_wide = 0;
  logic [31:0] d_wr_addr = '0;
  logic        d_wr_ready;
  logic [31:0] wr_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] mdl [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbw_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .p_rd_req(p_rd_req), .p_wr_req(p_wr_req), .p_wide(p_wide), .p_addr(p_addr),
    .p_rdata(p_rdata), .p_rd_ready(p_rd_ready), .p_wr_ready(p_wr_ready),
    .d_rd_req(d_rd_req), .d_rd_wide(d_rd_wide), .d_rd_addr(d_rd_addr),
    .d_rdata(d_rdata), .d_rd_ready(d_rd_ready),
    .d_wr_req(d_wr_req), .d_wr_wide(d_wr_wide), .d_wr_addr(d_wr_addr),
    .d_wr_ready(d_wr_ready), .wr_data(wr_data)
  );

  // Reference read: wide accesses pair word (a with bit0 cleared) low, its odd partner high.
  function automatic logic [31:0] ref_rd(input logic [31:0] a, input logic wide);
    logic [7:0] ev;
    ev = a[7:0] & 8'hFE;
    if (wide) return {mdl[ev + 8'd1], mdl[ev]};
    return {16'h0, mdl[a[7:0]]};
  endfunction

  task automatic ref_wr(input logic [31:0] a, input logic wide, input logic [31:0] d);
    logic [7:0] ev;
    ev = a[7:0] & 8'hFE;
    if (wide) begin
      mdl[ev] = d[15:0];
      mdl[ev + 8'd1] = d[31:16];
    end else begin
      mdl[a[7:0]] = d[15:0];
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    p_rd_req = 0; p_wr_req = 0; d_rd_req = 0; d_wr_req = 0;
  endtask

  // Drive at the falling edge, check mid-low phase, model the commit at the next rising edge.
  task automatic run_vec(input vec_t v, input int k);
    logic epwr, eprd, edrd, edwr;
    @(negedge clk);
    p_rd_req = v.prd; p_wr_req = v.pwr; p_wide = v.pw; p_addr = v.pa;
    d_rd_req = v.drd; d_rd_wide = v.drw; d_rd_addr = v.ra;
    d_wr_req = v.dwr; d_wr_wide = v.dww; d_wr_addr = v.wa;
    wr_data = v.wd;
    #1;
    epwr = v.pwr;
    eprd = v.prd && !v.pwr;
    edrd = v.drd;
    edwr = v.dwr && !v.pwr;
    chk($sformatf("R1 p_wr_ready vec%0d", k), 32'(p_wr_ready), 32'(epwr));
    chk($sformatf("R2 p_rd_ready vec%0d", k), 32'(p_rd_ready), 32'(eprd));
    chk($sformatf("R4 d_rd_ready vec%0d", k), 32'(d_rd_ready), 32'(edrd));
    chk($sformatf("R3 d_wr_ready vec%0d", k), 32'(d_wr_ready), 32'(edwr));
    if (eprd) chk($sformatf("R5 p_rdata vec%0d", k), p_rdata, ref_rd(32'(v.pa), v.pw));
    if (edrd) chk($sformatf("R8 d_rdata vec%0d", k), d_rdata, ref_rd(v.ra, v.drw));
    if (epwr) ref_wr(32'(v.pa), v.pw, v.wd);
    else if (edwr) ref_wr(v.wa, v.dww, v.wd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9: reset state, idle readys, cleared array
    idle();
    p_addr = 22'd5; p_wide = 1; d_rd_addr = 32'd200; d_rd_wide = 0;
    #1;
    chk("R9 idle readys", {28'h0, p_rd_ready, p_wr_ready, d_rd_ready, d_wr_ready}, 32'h0);
    chk("R9 p_rdata after reset", p_rdata, 32'h0);
    chk("R9 d_rdata after reset", d_rdata, 32'h0);

    for (int k = 0; k < NV; k++) run_vec(VEC[k], k);

    // R3: the stalled data write retries alone and then commits
    run_vec('{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0, 22'd0, 32'd0, 32'd3, 32'h0000_4444}, 100);
    run_vec('{1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0, 22'd0, 32'd3, 32'd0, 32'h0}, 101);

    // R7: narrow write to an odd word leaves its even partner alone
    run_vec('{1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 22'd5, 32'd0, 32'd0, 32'h1234_5678}, 102);
    run_vec('{1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0, 22'd4, 32'd4, 32'd0, 32'h0}, 103);

    // R9: address bits above the index width are ignored
    run_vec('{1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0, 22'd0, 32'h0001_0105, 32'd0, 32'h0}, 104);

    @(negedge clk); idle(); #1;
    chk("R9 idle after traffic", {28'h0, p_rd_ready, p_wr_ready, d_rd_ready, d_wr_ready}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule